// File: doc/BRIEF.md
# Voice Interrupt Pending Stack

This block gathers interrupt events raised by up to 32 synthesis voices when a voice reaches the end of its sample data or the end of its volume ramp. Each event arrives as a one-cycle push carrying a 5-bit voice number and two flags, one for a wave-end event and one for a ramp-end event. The block keeps these events in a last-in first-out store of parameterised depth, 1024 entries by default.

The host takes events one at a time with a one-cycle pop strobe. The popped event comes back as an 8-bit status byte with a fixed format. The block also drives two summary bits that mirror the flags of the entry now on top, and a level interrupt request. The request is gated by a global enable and falls whenever the host takes an event. A synchronous clear empties the store and returns every output to its reset value.

Top module: `voice_irq_stack`

## Requirements
- R1: After reset (`rst_n` low at a clock edge), the store is empty, `wave_pend`, `ramp_pend` and `irq_req` are 0, and `status_byte` reads 0xE0.
- R2: `status_byte` is registered and updates on the edge where `pop` is sampled high. Bit 7 is 1 when the taken entry is not a wave event. Bit 6 is 1 when it is not a ramp event. Bit 5 is always 1. Bits 4:0 hold the voice number.
- R3: Entries leave in reverse order of arrival: each pop returns the most recently pushed entry that is still stored.
- R4: A pop on an empty store returns voice 0 with both flags clear (0xE0) and leaves the store empty.
- R5: `wave_pend` and `ramp_pend` equal the flags of the entry on top of the store, so a push shows the pushed flags and a pop shows the flags of the next entry. Both are 0 when the store is empty.
- R6: A push while the store holds DEPTH entries, with no pop in the same cycle, is dropped. The top entry and the stored contents stay unchanged.
- R7: `irq_req` rises on the edge after one where the store is non-empty and `irq_en` is 1. It is 0 on the edge following any pop, and 0 on any edge where `irq_en` was 0.
- R8: A push and a pop in the same cycle return the incoming entry in `status_byte` and leave the store's depth and contents unchanged.
- R9: `clr` acts on the clock edge and takes priority over push and pop. The store empties, `status_byte` returns to 0xE0, and `irq_req`, `wave_pend` and `ramp_pend` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of the whole store |
| push | input | 1 | Event strobe from the voices |
| push_voice | input | 5 | Voice number of the pushed event |
| push_wave | input | 1 | Pushed event is a wave-end event |
| push_ramp | input | 1 | Pushed event is a ramp-end event |
| pop | input | 1 | Host read strobe; takes the top entry |
| irq_en | input | 1 | Global interrupt enable |
| status_byte | output | 8 | Encoded entry taken by the last pop |
| wave_pend | output | 1 | Wave flag of the current top entry |
| ramp_pend | output | 1 | Ramp flag of the current top entry |
| irq_req | output | 1 | Level interrupt request to the host |

## Verification
If the stack pointer is wrong, the fault shows on the very next pop. It appears as a wrong voice number or wrong flags in `status_byte`, and at once in the summary bits, which read the top entry directly. An off-by-one in the full limit only shows after a complete fill: a dropped push would appear, or a lost entry, on the first pop after the store fills. A count that stays non-empty after the last entry leaves keeps `irq_req` high one cycle after the drain and gives a non-0xE0 value on the extra pop.

// File: rtl/vis_pkg.sv
// Package: shared entry type for the voice interrupt pending stack.
// Assumes voice numbers fit in VIS_VOICE_W bits (32 voices).
package vis_pkg;
    localparam int VIS_VOICE_W = 5;

    typedef struct packed {
        logic                   wave;
        logic                   ramp;
        logic [VIS_VOICE_W-1:0] voice;
    } vis_entry_t;
endpackage

// File: rtl/vis_store.sv
// Module: vis_store
// Last-in first-out entry store with a depth counter. A push together
// with a pop leaves the store unchanged (the caller forwards the pushed
// entry). A push into a full store is dropped. Assumes DEPTH >= 2.
module vis_store
    import vis_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  vis_entry_t wr_data,
    output vis_entry_t top_out,
    output logic       nonempty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [CW-1:0] count_q;
    vis_entry_t    mem [DEPTH];
    logic          full;
    logic          commit_push;
    logic          commit_pop;
    logic [AW-1:0] top_idx;

    assign full        = (count_q == CW'(DEPTH));
    assign nonempty    = (count_q != '0);
    assign commit_push = wr_en && !rd_en && !full;
    assign commit_pop  = rd_en && !wr_en && nonempty;
    assign top_idx     = count_q[AW-1:0] - AW'(1);

    // Depth counter: clear first, then single push or single pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count_q <= '0;
        end else if (commit_push) begin
            count_q <= count_q + CW'(1);
        end else if (commit_pop) begin
            count_q <= count_q - CW'(1);
        end
    end

    // Entry array: write the new entry just above the current top.
    always_ff @(posedge clk) begin
        if (rst_n && !clr && commit_push) begin
            mem[count_q[AW-1:0]] <= wr_data;
        end
    end

    // Top entry read-out; zero when nothing is stored.
    always_comb begin
        top_out = '0;
        if (nonempty) begin
            top_out = mem[top_idx];
        end
    end

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    a_r8_pair_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !clr) |=> $stable(count_q));

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !nonempty);

    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !clr) |=> (count_q == CW'(DEPTH)));
endmodule

// File: rtl/vis_status_fmt.sv
// Module: vis_status_fmt
// Builds the host status byte from an entry: inverted wave flag, inverted
// ramp flag, a fixed 1, then the voice number. Purely combinational.
module vis_status_fmt
    import vis_pkg::*;
(
    input  vis_entry_t ent,
    output logic [7:0] code
);
    // Pack the inverted flags, the marker bit and the voice number.
    always_comb begin
        code = {~ent.wave, ~ent.ramp, 1'b1, ent.voice};
    end
endmodule

// File: rtl/voice_irq_stack.sv
// Module: voice_irq_stack
// Collects voice end-of-sample / end-of-ramp events in a LIFO store,
// returns one encoded entry per host pop, mirrors the top entry's flags
// and raises a level interrupt while entries wait and the enable is set.
// Assumes pop and push are single-cycle strobes from the same clock.
module voice_irq_stack
    import vis_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   push,
    input  logic [VIS_VOICE_W-1:0] push_voice,
    input  logic                   push_wave,
    input  logic                   push_ramp,
    input  logic                   pop,
    input  logic                   irq_en,
    output logic [7:0]             status_byte,
    output logic                   wave_pend,
    output logic                   ramp_pend,
    output logic                   irq_req
);
    localparam logic [7:0] IDLE_CODE = 8'hE0;

    vis_entry_t in_ent;
    vis_entry_t top_ent;
    vis_entry_t taken;
    logic       have_entry;
    logic [7:0] taken_code;
    logic [7:0] status_q;
    logic       irq_q;

    assign in_ent = '{wave: push_wave, ramp: push_ramp, voice: push_voice};

    vis_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_en    (push),
        .rd_en    (pop),
        .wr_data  (in_ent),
        .top_out  (top_ent),
        .nonempty (have_entry)
    );

    // Entry handed to the host: incoming one on a same-cycle push.
    always_comb begin
        taken = push ? in_ent : top_ent;
    end

    vis_status_fmt u_fmt (
        .ent  (taken),
        .code (taken_code)
    );

    // Status register: loads the encoded entry on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            status_q <= IDLE_CODE;
        end else if (pop) begin
            status_q <= taken_code;
        end
    end

    // Interrupt level: dropped by a read, otherwise follows enable and fill.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            irq_q <= 1'b0;
        end else if (pop) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_en && have_entry;
        end
    end

    assign status_byte = status_q;
    assign wave_pend   = top_ent.wave;
    assign ramp_pend   = top_ent.ramp;
    assign irq_req     = irq_q;

    a_r7_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !irq_req);

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_req);

    a_r5_pend_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_pend || ramp_pend) |-> have_entry);

    a_r9_clear_resets_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status_byte == IDLE_CODE && !irq_req && !wave_pend && !ramp_pend));
endmodule

// File: tb/sim_voice_irq_stack.sv
`timescale 1ns/1ps
module sim_voice_irq_stack;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       push = 1'b0;
    logic [4:0] push_voice = '0;
    logic       push_wave = 1'b0;
    logic       push_ramp = 1'b0;
    logic       pop = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] status_byte;
    logic       wave_pend;
    logic       ramp_pend;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    voice_irq_stack u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
        .push_voice(push_voice), .push_wave(push_wave), .push_ramp(push_ramp),
        .pop(pop), .irq_en(irq_en), .status_byte(status_byte),
        .wave_pend(wave_pend), .ramp_pend(ramp_pend), .irq_req(irq_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_push(input int v, input bit w, input bit r);
        push = 1'b1; push_voice = 5'(v); push_wave = w; push_ramp = r;
        tick();
        push = 1'b0;
    endtask

    task automatic do_pop();
        pop = 1'b1;
        tick();
        pop = 1'b0;
    endtask

    task automatic do_clr();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    function automatic int enc(input int v, input bit w, input bit r);
        return {~w, ~r, 1'b1, 5'(v)};
    endfunction

    task automatic t_reset();
        chk("R1 status", status_byte, 8'hE0);
        chk("R1 pend", {wave_pend, ramp_pend}, 0);
        chk("R1 irq", irq_req, 0);
    endtask

    task automatic t_lifo();
        do_push(7, 0, 0); do_push(8, 0, 0); do_push(9, 0, 0);
        do_pop(); chk("R3 first", status_byte, 8'hE9);
        do_pop(); chk("R3 second", status_byte, 8'hE8);
        do_pop(); chk("R3 third", status_byte, 8'hE7);
    endtask

    task automatic t_empty_pop();
        do_pop();
        chk("R4 code", status_byte, 8'hE0);
        chk("R4 pend", {wave_pend, ramp_pend}, 0);
        do_push(12, 1, 0); do_pop();
        chk("R4 still empty before", status_byte, enc(12, 1, 0));
    endtask

    task automatic t_summary();
        do_push(3, 1, 0);
        chk("R5 after push A", {wave_pend, ramp_pend}, 2'b10);
        do_push(4, 0, 1);
        chk("R5 after push B", {wave_pend, ramp_pend}, 2'b01);
        do_pop();
        chk("R2 code B", status_byte, 8'hA4);
        chk("R5 next top", {wave_pend, ramp_pend}, 2'b10);
        do_pop();
        chk("R2 code A", status_byte, 8'h63);
        chk("R5 empty", {wave_pend, ramp_pend}, 0);
    endtask

    task automatic t_irq();
        irq_en = 1'b1;
        do_push(1, 1, 1);
        chk("R7 not yet", irq_req, 0);
        tick();
        chk("R7 raised", irq_req, 1);
        do_push(2, 1, 1);
        do_pop();
        chk("R7 read drops", irq_req, 0);
        tick();
        chk("R7 re-raised", irq_req, 1);
        irq_en = 1'b0;
        tick();
        chk("R7 disabled", irq_req, 0);
        do_clr();
    endtask

    task automatic t_pair();
        do_push(10, 1, 1);
        push = 1'b1; push_voice = 5'd20; push_wave = 1'b0; push_ramp = 1'b1;
        pop = 1'b1;
        tick();
        push = 1'b0; pop = 1'b0;
        chk("R8 incoming", status_byte, 8'hB4);
        chk("R8 top kept", {wave_pend, ramp_pend}, 2'b11);
        do_pop(); chk("R8 old entry", status_byte, 8'h2A);
        do_pop(); chk("R8 depth kept", status_byte, 8'hE0);
    endtask

    task automatic t_clear();
        irq_en = 1'b1;
        do_push(6, 1, 0); do_push(11, 0, 1);
        tick();
        clr = 1'b1; push = 1'b1; push_voice = 5'd17; push_wave = 1'b1; pop = 1'b1;
        tick();
        clr = 1'b0; push = 1'b0; pop = 1'b0; push_wave = 1'b0;
        chk("R9 status", status_byte, 8'hE0);
        chk("R9 irq", irq_req, 0);
        chk("R9 pend", {wave_pend, ramp_pend}, 0);
        tick();
        chk("R9 irq stays low", irq_req, 0);
        do_pop();
        chk("R9 emptied", status_byte, 8'hE0);
        irq_en = 1'b0;
    endtask

    task automatic t_full();
        for (int i = 0; i < 1024; i++) begin
            do_push(i % 32, i[0], i[1]);
        end
        do_push(5, 0, 0);
        chk("R6 top unchanged", {wave_pend, ramp_pend}, 2'b11);
        do_pop();
        chk("R6 dropped push", status_byte, 8'h3F);
        for (int i = 1022; i >= 0; i--) begin
            do_pop();
            chk("R6 R3 drain", status_byte, enc(i % 32, i[0], i[1]));
        end
        chk("R6 drained pend", {wave_pend, ramp_pend}, 0);
        do_pop();
        chk("R6 R4 extra pop", status_byte, 8'hE0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_lifo();
        t_empty_pop();
        t_summary();
        t_irq();
        t_pair();
        t_clear();
        t_full();
        finish_run();
    end
endmodule